// File: doc/BRIEF.md
# Dual-Compare 64-bit Time Base

This block keeps a 64-bit binary count that advances by one on every cycle in which the tick-enable input is high. Software reaches the count only through two 32-bit windows, one for the lower half and one for the upper half. Each window can be read and written on its own. No reset changes the count, so software must load both halves before it relies on the value.

Two 32-bit reference registers are each compared with the lower half of the count. A match is taken only on the edge where the lower half advances by a tick into the reference value. It sets a sticky status bit for that reference. A status bit set together with its enable bit drives the level interrupt output high. Status bits are cleared by writing one to them.

Word map on `bus_addr`: 0 = count low, 1 = count high, 2 = reference A, 3 = reference B, 4 = control/status. All other addresses read as zero and writes to them are ignored.

Top module: `tbase64_dual_cmp`

## Requirements
- R1: On each clock edge with `tick_en` high and no write to the count, the 64-bit count increases by exactly one. With `tick_en` low and no write, the count holds.
- R2: Carry from the lower half goes into the upper half. The count wraps from all ones to zero.
- R3: `rst_n` does not change the count. The count keeps responding to `tick_en` while reset is low.
- R4: A write to address 0 replaces only the lower half, and no increment happens that cycle. A write to address 1 replaces only the upper half, and the lower half still advances if `tick_en` is high. The written value wins over the increment.
- R5: `bus_rdata` gives the current state without delay. Address 0 returns count[31:0]. Address 1 returns count[63:32]. Address 2 returns reference A. Address 3 returns reference B. Address 4 returns the enables in bits [1:0] (bit 0 for A, bit 1 for B) and the status flags in bits [9:8] (bit 8 for A, bit 9 for B), with zeros elsewhere. Addresses 5 to 7 return zero.
- R6: A status bit is set on the edge where a tick moves the lower half of the count to a value equal to its reference. Writing the count to that value, or holding at that value without a tick, sets nothing. A reference behind the count fires only after the lower half wraps back round to it.
- R7: A status bit stays set until a write to address 4 has a one in its bit position (8 or 9). If that clear happens on the same edge as a new match, the bit stays set.
- R8: A match sets its status bit even when the matching enable bit is zero.
- R9: `irq` is high exactly when some status bit and its enable bit are both set. It follows the register state without delay.
- R10: With `rst_n` low at a clock edge, the enable bits, the status bits and both references become zero.
- R11: The two references act independently. When both match on the same edge, both status bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (leaves the count alone) |
| tick_en | input | 1 | One-cycle count enable |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Level interrupt request |

## Verification
Reads have no delay, so a write or tick at one edge appears on `bus_rdata` right after that edge. A match sets its status bit and `irq` on the same edge that moves the count onto the reference. The bench drives each cycle's inputs just after a falling edge. It compares the read word and `irq` with its own model one time unit later, before the next rising edge. It then advances the model at that rising edge with the same inputs, so the model and the design always describe the same edge. Count reads are compared only after both halves have been loaded, because the count starts undefined.

// File: rtl/tbase_pkg.sv
// Shared widths and word addresses for the dual-compare time base.
// Assumes two references and a 3-bit word address space.
package tbase_pkg;
    localparam int HALF_W = 32;
    localparam int CNT_W  = 2 * HALF_W;
    localparam int N_REF  = 2;
    localparam int ADDR_W = 3;
    localparam int ST_LSB = 8;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_CNT_LO = addr_t'(0);
    localparam addr_t A_CNT_HI = addr_t'(1);
    localparam addr_t A_REF0   = addr_t'(2);
    localparam addr_t A_CTL    = addr_t'(2 + N_REF);
endpackage

// File: rtl/tbase_counter.sv
// 64-bit free-running count, written in two halves.
// Assumes at most one half is written per cycle. The count has no reset on purpose.
module tbase_counter #(
    parameter int HALF_W = 32,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              adv_lo,
    output logic [HALF_W-1:0] step_lo
);
    logic [CNT_W-1:0] inc;

    // Incremented value and the low-half advance qualifier.
    always_comb begin
        inc     = cnt_q + CNT_W'(1);
        adv_lo  = tick_en && !wr_lo;
        step_lo = inc[HALF_W-1:0];
    end

    // Count update: half writes win over the increment; reset is not used.
    always_ff @(posedge clk) begin
        if (wr_lo) begin
            cnt_q[HALF_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cnt_q[CNT_W-1:HALF_W] <= wdata;
            if (tick_en) cnt_q[HALF_W-1:0] <= inc[HALF_W-1:0];
        end else if (tick_en) begin
            cnt_q <= inc;
        end
    end

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_lo && !wr_hi) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_lo && !wr_hi) |=> $stable(cnt_q)); // R1
    AST_WR_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_q[HALF_W-1:0] == $past(wdata)) &&
                  (cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W]))); // R4
    AST_WR_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (cnt_q[CNT_W-1:HALF_W] == $past(wdata))); // R4
endmodule

// File: rtl/tbase_match.sv
// Reference registers and equality detectors, one of each per reference.
// Assumes a hit is wanted only when the low half advances into the reference.
module tbase_match #(
    parameter int HALF_W = 32,
    parameter int N_REF  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REF-1:0]        wr_ref,
    input  logic [HALF_W-1:0]       wdata,
    input  logic                    adv_lo,
    input  logic [HALF_W-1:0]       step_lo,
    output logic [N_REF*HALF_W-1:0] ref_q,
    output logic [N_REF-1:0]        hit
);
    for (genvar k = 0; k < N_REF; k++) begin : g_ref
        logic [HALF_W-1:0] ref_r;

        // Reference storage, cleared by reset, loaded by its own write.
        always_ff @(posedge clk) begin
            if (!rst_n)         ref_r <= '0;
            else if (wr_ref[k]) ref_r <= wdata;
        end

        // Match on the value the low half is about to take.
        always_comb begin
            hit[k] = adv_lo && (step_lo == ref_r);
        end

        assign ref_q[k*HALF_W +: HALF_W] = ref_r;
    end
endmodule

// File: rtl/tbase_csr.sv
// Per-reference enable and sticky status flags, and the level interrupt.
// Assumes a match on the same edge as a clear leaves the flag set.
module tbase_csr #(
    parameter int N_REF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [N_REF-1:0] en_wdata,
    input  logic [N_REF-1:0] clr_wdata,
    input  logic [N_REF-1:0] hit,
    output logic [N_REF-1:0] en_q,
    output logic [N_REF-1:0] st_q,
    output logic             irq
);
    // Enable bits are loaded as a whole on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_ctl) en_q <= en_wdata;
    end

    for (genvar k = 0; k < N_REF; k++) begin : g_st
        // Sticky flag: set by a hit, cleared by writing one.
        always_ff @(posedge clk) begin
            if (!rst_n) st_q[k] <= 1'b0;
            else        st_q[k] <= hit[k] | (st_q[k] & ~(wr_ctl & clr_wdata[k]));
        end

        AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |=> st_q[k]); // R8
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[k] && !(wr_ctl && clr_wdata[k])) |=> st_q[k]); // R7
        AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_q[k] && !hit[k]) |=> !st_q[k]); // R6
    end

    // Level interrupt from any enabled flag.
    always_comb begin
        irq = |(st_q & en_q);
    end
endmodule

// File: rtl/tbase64_dual_cmp.sv
// Top of the dual-compare time base: address decode, read mux and submodules.
// Assumes one bus write per cycle and reads with no delay.
module tbase64_dual_cmp
    import tbase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);
    logic                    wr_lo, wr_hi, wr_ctl, adv_lo;
    logic [N_REF-1:0]        wr_ref, hit, en_q, st_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [HALF_W-1:0]       step_lo;
    logic [N_REF*HALF_W-1:0] ref_q;

    // Write strobes per register.
    always_comb begin
        wr_lo  = bus_wr && (bus_addr == A_CNT_LO);
        wr_hi  = bus_wr && (bus_addr == A_CNT_HI);
        wr_ctl = bus_wr && (bus_addr == A_CTL);
    end

    for (genvar k = 0; k < N_REF; k++) begin : g_dec
        assign wr_ref[k] = bus_wr && (bus_addr == ADDR_W'(A_REF0 + k));
    end

    tbase_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(bus_wdata), .cnt_q(cnt_q), .adv_lo(adv_lo), .step_lo(step_lo)
    );

    tbase_match #(.HALF_W(HALF_W), .N_REF(N_REF)) u_match (
        .clk(clk), .rst_n(rst_n), .wr_ref(wr_ref), .wdata(bus_wdata),
        .adv_lo(adv_lo), .step_lo(step_lo), .ref_q(ref_q), .hit(hit)
    );

    tbase_csr #(.N_REF(N_REF)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl),
        .en_wdata(bus_wdata[N_REF-1:0]), .clr_wdata(bus_wdata[ST_LSB +: N_REF]),
        .hit(hit), .en_q(en_q), .st_q(st_q), .irq(irq)
    );

    // Read mux over the word map.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CNT_LO) bus_rdata = cnt_q[HALF_W-1:0];
        if (bus_addr == A_CNT_HI) bus_rdata = cnt_q[CNT_W-1:HALF_W];
        for (int k = 0; k < N_REF; k++) begin
            if (bus_addr == ADDR_W'(A_REF0 + k)) bus_rdata = ref_q[k*HALF_W +: HALF_W];
        end
        if (bus_addr == A_CTL) begin
            bus_rdata[N_REF-1:0]       = en_q;
            bus_rdata[ST_LSB +: N_REF] = st_q;
        end
    end

    for (genvar k = 0; k < N_REF; k++) begin : g_chk
        AST_HIT_EQUALS_REF: assert property (@(posedge clk) disable iff (!rst_n)
            hit[k] |=> (cnt_q[HALF_W-1:0] == $past(ref_q[k*HALF_W +: HALF_W]))); // R6
    end
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q != '0) && (en_q != '0)); // R9
endmodule

// File: tb/tbase64_dual_cmp_tb.sv
module tbase64_dual_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n, tick_en, bus_wr, irq;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    int checks = 0, fails = 0;

    longint unsigned m_cnt = 0;
    bit          m_cnt_ok = 0;
    logic [31:0] m_ref [2];
    logic [1:0]  m_en, m_st;

    always #4 clk = ~clk;

    tbase64_dual_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt[31:0];
            3'd1: return m_cnt[63:32];
            3'd2: return m_ref[0];
            3'd3: return m_ref[1];
            3'd4: return {22'd0, m_st, 6'd0, m_en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input bit w, input logic [2:0] a, input logic [31:0] d, input bit t);
        longint unsigned nxt = m_cnt;
        logic [31:0] lo_step = m_cnt[31:0] + 32'd1;
        bit adv = t && !(w && a == 3'd0);
        logic [1:0] hit;
        for (int k = 0; k < 2; k++) hit[k] = adv && (lo_step == m_ref[k]);
        if (w && a == 3'd0)      nxt = {m_cnt[63:32], d};
        else if (w && a == 3'd1) nxt = {d, (t ? lo_step : m_cnt[31:0])};
        else if (t)              nxt = m_cnt + 1;
        if (!rst_n) begin
            m_en = 0; m_st = 0; m_ref[0] = 0; m_ref[1] = 0;
        end else begin
            if (w && a == 3'd4) begin m_en = d[1:0]; m_st = m_st & ~d[9:8]; end
            m_st = m_st | hit;
            if (w && a == 3'd2) m_ref[0] = d;
            if (w && a == 3'd3) m_ref[1] = d;
        end
        m_cnt = nxt;
    endtask

    // One cycle: drive, compare before the edge, advance the model at the edge.
    task automatic step(input string tag, input bit w, input logic [2:0] a,
                        input logic [31:0] d, input bit t);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = t;
        #1;
        if (m_cnt_ok || a > 3'd1) check(tag, bus_rdata, m_read(a));
        check({tag, "/R9 irq"}, {31'd0, irq}, {31'd0, |(m_st & m_en)});
        @(posedge clk);
        model(w, a, d, t);
        @(negedge clk);
    endtask

    task automatic ticks(input string tag, input int n, input logic [2:0] a);
        for (int i = 0; i < n; i++) step(tag, 0, a, 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; tick_en = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        m_ref[0] = 0; m_ref[1] = 0; m_en = 0; m_st = 0;
        @(negedge clk);
        step("R10 reset", 0, 3'd2, 0, 0);
        step("R10 reset", 0, 3'd2, 0, 0);
        step("R10 refA", 0, 3'd2, 0, 0);
        step("R10 refB", 0, 3'd3, 0, 0);
        step("R10 ctl", 0, 3'd4, 0, 0);
        rst_n = 1;
        // load count
        step("R4 load lo", 1, 3'd0, 32'hFFFF_FFF0, 0);
        step("R4 load hi", 1, 3'd1, 32'h0000_0007, 0);
        m_cnt_ok = 1;
        step("R4 read lo", 0, 3'd0, 0, 0);
        ticks("R1 count lo", 8, 3'd0);
        ticks("R2 carry lo", 12, 3'd0);
        step("R2 carry hi", 0, 3'd1, 0, 0);
        for (int i = 0; i < 6; i++) step("R1 gap", 0, 3'd0, 0, i % 2);
        step("R1 hold", 0, 3'd0, 0, 0);
        // full 64-bit wrap
        step("R4 wr lo", 1, 3'd0, 32'hFFFF_FFFE, 0);
        step("R4 wr hi", 1, 3'd1, 32'hFFFF_FFFF, 0);
        ticks("R2 wrap hi", 3, 3'd1);
        step("R2 wrap lo", 0, 3'd0, 0, 0);
        // write precedence
        step("R4 wr hi w/ tick", 1, 3'd1, 32'h1234_5678, 1);
        step("R4 hi after", 0, 3'd1, 0, 0);
        step("R4 lo after", 0, 3'd0, 0, 0);
        step("R4 wr lo w/ tick", 1, 3'd0, 32'h0000_00F0, 1);
        step("R4 lo after", 0, 3'd0, 0, 0);
        step("R4 hi kept", 0, 3'd1, 0, 0);
        step("R4 hi zero", 1, 3'd1, 0, 0);
        // reference A with enable
        step("R5 wr refA", 1, 3'd2, 32'h0000_0100, 0);
        step("R5 refA", 0, 3'd2, 0, 0);
        step("R5 refB", 0, 3'd3, 0, 0);
        step("R5 en A", 1, 3'd4, 32'h1, 0);
        ticks("R6 approach A", 20, 3'd4);
        step("R6 flag A", 0, 3'd4, 0, 0);
        step("R5 unmapped", 0, 3'd5, 0, 0);
        step("R5 unmapped", 0, 3'd7, 0, 0);
        step("R7 clear A", 1, 3'd4, 32'h101, 0);
        ticks("R7 stays clear", 4, 3'd4);
        // passed reference B
        step("R11 wr refB", 1, 3'd3, 32'h0000_0050, 0);
        step("R6 en B", 1, 3'd4, 32'h3, 0);
        ticks("R6 passed", 5, 3'd4);
        step("R6 wr equal", 1, 3'd0, 32'h0000_0050, 0);
        step("R6 no fire", 0, 3'd4, 0, 1);
        step("R6 lo before", 1, 3'd0, 32'h0000_004F, 0);
        step("R6 no tick", 0, 3'd4, 0, 0);
        step("R6 tick in", 0, 3'd4, 0, 1);
        step("R6 flag B", 0, 3'd4, 0, 0);
        // enable off
        step("R8 clr all", 1, 3'd4, 32'h300, 0);
        step("R8 lo", 1, 3'd0, 32'h0000_00FE, 0);
        ticks("R8 flag no irq", 3, 3'd4);
        step("R9 enable", 1, 3'd4, 32'h1, 0);
        step("R9 irq on", 0, 3'd4, 0, 0);
        // both refs together
        step("R11 refB same", 1, 3'd3, 32'h0000_0200, 0);
        step("R11 refA same", 1, 3'd2, 32'h0000_0200, 0);
        step("R11 clr", 1, 3'd4, 32'h303, 0);
        step("R11 lo", 1, 3'd0, 32'h0000_01FE, 0);
        ticks("R11 both", 3, 3'd4);
        // clear and hit on the same edge
        step("R7 lo", 1, 3'd0, 32'h0000_01FF, 0);
        step("R7 set wins", 1, 3'd4, 32'h103, 1);
        step("R7 set kept", 0, 3'd4, 0, 0);
        // reset leaves the count
        step("R3 lo", 1, 3'd0, 32'h0000_1000, 0);
        rst_n = 0;
        ticks("R3 tick in reset", 5, 3'd0);
        rst_n = 1;
        step("R3 lo after", 0, 3'd0, 0, 0);
        step("R3 hi after", 0, 3'd1, 0, 0);
        step("R10 ctl after", 0, 3'd4, 0, 0);
        step("R10 refA after", 0, 3'd2, 0, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule